// File: doc/BRIEF.md
# Dual-Mode Control Port Slave

This block is a serial control-port slave. A host uses it to fill, and read back, a small bank of 8-bit configuration registers. After reset it acts as an I2C slave. It samples the bus clock and data lines into the system clock domain and finds START and STOP conditions and SCL edges. A state machine then steps through the address byte, the pointer byte and the data bytes. The register bank is outside the block. The block reaches it through a one-cycle write strobe with address and data, and through a combinational read port addressed by the current pointer.

The pointer byte does two jobs. Its low bits choose the register. Its most significant bit chooses whether the pointer moves forward by one after each data byte, in either direction of transfer. The pointer wraps from the last register to register 0, and it is kept across transactions. The address/select pin also supplies the lowest bit of the slave address. A falling edge on that pin at any time after reset moves the port into SPI mode for good. In SPI mode the I2C engine stays idle, never drives SDA and never writes. SPI framing itself is not part of this block.

The state machine has these states:
- `ST_IDLE`: nothing in progress.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_PTR`: shifting in the pointer byte.
- `ST_PTR_ACK`: acknowledging the pointer.
- `ST_WDATA`: shifting in a write data byte.
- `ST_WDATA_ACK`: acknowledging a write data byte.
- `ST_RDATA`: shifting out a read data byte.
- `ST_RACK`: waiting for the master's acknowledge.
- `ST_IGNORE`: ignoring the bus.

Its transitions are:
- START from any state goes to `ST_ADDR`.
- STOP goes to `ST_IDLE`.
- In SPI mode the machine is held in `ST_IDLE`.
- In `ST_ADDR`, on the eighth rising SCL edge, a matching address goes to `ST_ADDR_ACK` and a mismatch goes to `ST_IGNORE`.
- On the falling SCL edge that ends an acknowledge:
  - `ST_ADDR_ACK` goes to `ST_RDATA` for a read, or to `ST_PTR` for a write.
  - `ST_PTR_ACK` goes to `ST_WDATA`.
  - `ST_WDATA_ACK` goes back to `ST_WDATA`.
- The eighth rising edge in `ST_PTR` goes to `ST_PTR_ACK`.
- The eighth rising edge in `ST_WDATA` goes to `ST_WDATA_ACK`.
- The eighth falling edge in `ST_RDATA` goes to `ST_RACK`.
- In `ST_RACK`:
  - A master NACK goes to `ST_IGNORE`.
  - A master ACK goes back to `ST_RDATA` on the next falling edge.

Top module: `ctlport_slave`

## Requirements
- R1: After reset the port is in I2C mode, `sda_oe_o` is 0 and `wr_en_o` is 0.
- R2: An address byte is acknowledged only if its upper seven bits equal 0011000 with the lowest of the seven replaced by the level of `sel_i` (bit 0 of the byte is R/W, 1 = read). The acknowledge is `sda_oe_o` = 1 (SDA held low) during the ninth SCL clock.
- R3: After a non-matching address byte the slave does not acknowledge that byte or any later byte, and writes nothing, until the next START or STOP.
- R4: In a write, the pointer byte is acknowledged. Its low four bits select the register and its bit 7 is the increment flag. Every following data byte is acknowledged and written with a `wr_en_o` pulse one cycle long.
- R5: With the increment flag at 1, the pointer advances by one after each data byte and wraps from register 15 to register 0.
- R6: With the increment flag at 0, successive data bytes all target the same register, and the last one written remains.
- R7: In a read (R/W = 1) the slave sends the register at the pointer, MSB first. The pointer advances after each acknowledged byte only when the increment flag is 1.
- R8: A master NACK after a read byte makes the slave release SDA. It ignores further clocks until START or STOP.
- R9: A repeated START restarts decoding at the address byte. The pointer keeps its value across a repeated START and across STOP.
- R10: A falling edge on `sel_i` after reset sets `spi_mode_o` permanently. From then on the slave never drives SDA and never writes. A rising edge on `sel_i` does not change the mode.
- R11: `sda_oe_o` changes only while SCL is low, except when START, STOP or the mode switch forces it off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open drain) |
| sel_i | input | 1 | Address strap bit / chip-select pin |
| spi_mode_o | output | 1 | Sticky flag: port has switched to SPI mode |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 4 | Register index for the write |
| wr_data_o | output | 8 | Data for the write |
| rd_addr_o | output | 4 | Current pointer, used as the read index |
| rd_data_i | input | 8 | Register contents at `rd_addr_o` |

## Verification
The bench drives a block write that starts at register 14. A design that does not wrap the pointer would write the third byte to a register that does not exist, or would leave register 0 unchanged. Reads that follow a repeated START, and reads after a STOP with no new pointer, show whether the pointer was lost or advanced when the flag was clear. A master NACK followed by more clocking, and a wrong address followed by a data byte, are watched on every clock for any SDA drive or write strobe. Finally the strap pin is raised, which must move the matching address to 0x32. It is then lowered, which must silence the port for good, so a design that watched the wrong edge or did not latch the mode would still acknowledge.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } ctlp_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/ctlp_sync.sv
module ctlp_sync #(
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                stab_q <= RST_VAL[g];
            end else begin
                meta_q <= d_i[g];
                stab_q <= meta_q;
            end
        end
        assign q_o[g] = stab_q;
    end

endmodule

// File: rtl/ctlp_cond.sv
module ctlp_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    input  logic sel_s,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic spi_mode_o
);

    logic scl_q;
    logic sda_q;
    logic sel_q;
    logic spi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            sel_q <= 1'b0;
            spi_q <= 1'b0;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
            sel_q <= sel_s;
            if (sel_q && !sel_s) begin
                spi_q <= 1'b1;
            end
        end
    end

    assign start_o    = scl_q && scl_s && sda_q && !sda_s;
    assign stop_o     = scl_q && scl_s && !sda_q && sda_s;
    assign scl_rise_o = !scl_q && scl_s;
    assign scl_fall_o = scl_q && !scl_s;
    assign spi_mode_o = spi_q;

    AST_SPI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        spi_q |=> spi_q); // R10

    AST_SPI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_s) |=> spi_q); // R10

endmodule

// File: rtl/ctlp_engine.sv
module ctlp_engine
    import ctlp_pkg::*;
#(
    parameter int          AW      = 4,
    parameter logic [5:0]  ADDR_HI = 6'b001100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              scl_s_i,
    input  logic              sda_s_i,
    input  logic              sel_s_i,
    input  logic              spi_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic              wr_en_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic [AW-1:0]     rd_addr_o
);

    ctlp_state_e       state_q, state_d;
    logic [BYTE_W-1:0] sh_q;
    logic [2:0]        cnt_q;
    logic              flag_q;
    logic              rw_q;
    logic              incr_q;
    logic [AW-1:0]     ptr_q;
    logic              wr_en_q;
    logic [AW-1:0]     wr_addr_q;
    logic [BYTE_W-1:0] wr_data_q;

    logic [BYTE_W-1:0] byte_in;
    logic              last_bit;
    logic              addr_hit;

    assign byte_in  = {sh_q[BYTE_W-2:0], sda_s_i};
    assign last_bit = (cnt_q == 3'd7);
    assign addr_hit = (byte_in[BYTE_W-1:1] == {ADDR_HI, sel_s_i});

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (spi_i) begin
            state_d = ST_IDLE;
        end else if (start_i) begin
            state_d = ST_ADDR;
        end else if (stop_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_ADDR:
                    if (scl_rise_i && last_bit)
                        state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:
                    if (scl_fall_i && flag_q)
                        state_d = rw_q ? ST_RDATA : ST_PTR;
                ST_PTR:
                    if (scl_rise_i && last_bit) state_d = ST_PTR_ACK;
                ST_PTR_ACK:
                    if (scl_fall_i && flag_q) state_d = ST_WDATA;
                ST_WDATA:
                    if (scl_rise_i && last_bit) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK:
                    if (scl_fall_i && flag_q) state_d = ST_WDATA;
                ST_RDATA:
                    if (scl_fall_i && last_bit) state_d = ST_RACK;
                ST_RACK: begin
                    if (scl_rise_i && sda_s_i) state_d = ST_IGNORE;
                    else if (scl_fall_i && flag_q) state_d = ST_RDATA;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '1;
            cnt_q     <= '0;
            flag_q    <= 1'b0;
            rw_q      <= 1'b0;
            incr_q    <= 1'b0;
            ptr_q     <= '0;
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (spi_i || start_i || stop_i) begin
                cnt_q  <= '0;
                flag_q <= 1'b0;
                sh_q   <= '1;
            end else begin
                unique case (state_q)
                    ST_ADDR: if (scl_rise_i) begin
                        sh_q  <= byte_in;
                        cnt_q <= cnt_q + 3'd1;
                        if (last_bit) rw_q <= sda_s_i;
                    end
                    ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: if (scl_fall_i) begin
                        if (!flag_q) begin
                            flag_q <= 1'b1;
                        end else begin
                            flag_q <= 1'b0;
                            cnt_q  <= '0;
                            if (state_q == ST_ADDR_ACK && rw_q) sh_q <= rd_data_i;
                            else                                 sh_q <= '1;
                        end
                    end
                    ST_PTR: if (scl_rise_i) begin
                        sh_q  <= byte_in;
                        cnt_q <= cnt_q + 3'd1;
                        if (last_bit) begin
                            incr_q <= byte_in[BYTE_W-1];
                            ptr_q  <= byte_in[AW-1:0];
                        end
                    end
                    ST_WDATA: if (scl_rise_i) begin
                        sh_q  <= byte_in;
                        cnt_q <= cnt_q + 3'd1;
                        if (last_bit) begin
                            wr_en_q   <= 1'b1;
                            wr_addr_q <= ptr_q;
                            wr_data_q <= byte_in;
                            if (incr_q) ptr_q <= ptr_q + 1'b1;
                        end
                    end
                    ST_RDATA: if (scl_fall_i) begin
                        if (last_bit) begin
                            cnt_q <= '0;
                            sh_q  <= '1;
                        end else begin
                            sh_q  <= {sh_q[BYTE_W-2:0], 1'b1};
                            cnt_q <= cnt_q + 3'd1;
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise_i && !sda_s_i) begin
                            flag_q <= 1'b1;
                            if (incr_q) ptr_q <= ptr_q + 1'b1;
                        end else if (scl_fall_i && flag_q) begin
                            flag_q <= 1'b0;
                            sh_q   <= rd_data_i;
                            cnt_q  <= '0;
                        end
                    end
                    default: begin
                        cnt_q  <= '0;
                        flag_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    // output decode
    always_comb begin
        sda_oe_o = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe_o = flag_q;
            ST_RDATA:                               sda_oe_o = !sh_q[BYTE_W-1];
            default:                                sda_oe_o = 1'b0;
        endcase
    end

    assign wr_en_o   = wr_en_q;
    assign wr_addr_o = wr_addr_q;
    assign wr_data_o = wr_data_q;
    assign rd_addr_o = ptr_q;

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe_o) && !$past(start_i || stop_i || spi_i)) |-> !scl_s_i); // R11

    AST_SPI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        spi_i |=> (!sda_oe_o && !wr_en_o)); // R10

    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o); // R4

    AST_NO_WR_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_IGNORE, ST_RDATA, ST_RACK}) |-> !wr_en_o); // R3

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && incr_q) |-> (ptr_q == AW'(wr_addr_o + 1'b1))); // R5

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && !incr_q) |-> (ptr_q == wr_addr_o)); // R6

endmodule

// File: rtl/ctlport_slave.sv
module ctlport_slave
    import ctlp_pkg::*;
#(
    parameter int         NREG    = 16,
    parameter logic [5:0] ADDR_HI = 6'b001100,
    localparam int        AW      = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              sel_i,
    output logic              spi_mode_o,
    output logic              wr_en_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic [AW-1:0]     rd_addr_o,
    input  logic [BYTE_W-1:0] rd_data_i
);

    logic [2:0] pins_s;
    logic       start, stop, scl_rise, scl_fall, spi_mode;

    ctlp_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sel_i, sda_i, scl_i}),
        .q_o   (pins_s)
    );

    ctlp_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (pins_s[0]),
        .sda_s      (pins_s[1]),
        .sel_s      (pins_s[2]),
        .start_o    (start),
        .stop_o     (stop),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .spi_mode_o (spi_mode)
    );

    ctlp_engine #(.AW(AW), .ADDR_HI(ADDR_HI)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .stop_i     (stop),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .scl_s_i    (pins_s[0]),
        .sda_s_i    (pins_s[1]),
        .sel_s_i    (pins_s[2]),
        .spi_i      (spi_mode),
        .rd_data_i  (rd_data_i),
        .sda_oe_o   (sda_oe_o),
        .wr_en_o    (wr_en_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .rd_addr_o  (rd_addr_o)
    );

    assign spi_mode_o = spi_mode;

endmodule

// File: tb/ctlport_slave_tb.sv
`timescale 1ns/1ps
module ctlport_slave_tb;

    localparam int Q  = 8;
    localparam int WD = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sel = 1'b0;
    logic       sda_line;
    logic       sda_oe, spi_mode, wr_en;
    logic [3:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;

    logic [7:0] bank  [16];
    logic [7:0] ebank [16];

    int n_chk = 0, n_fail = 0;
    int wr_seen = 0;
    int viol = 0;
    bit quiet = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = bank[rd_addr];

    ctlport_slave u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .sel_i      (sel),
        .spi_mode_o (spi_mode),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .rd_addr_o  (rd_addr),
        .rd_data_i  (rd_data)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) bank[i] <= 8'h00;
        end else if (wr_en) begin
            bank[wr_addr] <= wr_data;
        end
    end

    // per-clock monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) wr_seen++;
            if (quiet && (sda_oe || wr_en)) viol++;
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_bank(input string req);
        int bad = 0;
        for (int i = 0; i < 16; i++) begin
            if (bank[i] !== ebank[i]) begin
                bad++;
                $display("FAIL %s reg%0d actual=%0h expected=%0h", req, i, bank[i], ebank[i]);
            end
        end
        n_chk++;
        if (bad != 0) n_fail++;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(Q);
        scl = 1'b1;   wt(Q);
        sda_m = 1'b0; wt(Q);
        scl = 1'b0;   wt(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(Q);
        scl = 1'b1;   wt(Q);
        sda_m = 1'b1; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(Q);
            scl = 1'b1;   wt(Q);
            scl = 1'b0;   wt(Q);
        end
        sda_m = 1'b1; wt(Q);
        scl = 1'b1;   wt(Q);
        ack = (sda_line == 1'b0);
        scl = 1'b0;   wt(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(Q);
            scl = 1'b1; wt(Q);
            b[i] = sda_line;
            scl = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1; wt(Q);
        scl = 1'b1; wt(Q);
        scl = 1'b0; wt(Q);
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] rb;
        int w0;
        for (int i = 0; i < 16; i++) ebank[i] = 8'h00;
        wt(10);
        rst_n = 1'b1;
        wt(10);

        // R1 reset state
        chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        chk(wr_en == 1'b0, "R1 wr_en", wr_en, 0);
        chk(spi_mode == 1'b0, "R1 spi_mode", spi_mode, 0);

        // R4/R5 block write with increment, wrapping 14,15,0
        w0 = wr_seen;
        bus_start();
        send_byte(8'h30, ack); chk(ack, "R2 addr ack", ack, 1);
        send_byte(8'h8E, ack); chk(ack, "R4 ptr ack", ack, 1);
        send_byte(8'hA1, ack); chk(ack, "R4 data ack", ack, 1);
        send_byte(8'hB2, ack); chk(ack, "R4 data ack", ack, 1);
        send_byte(8'hC3, ack); chk(ack, "R4 data ack", ack, 1);
        bus_stop();
        ebank[14] = 8'hA1; ebank[15] = 8'hB2; ebank[0] = 8'hC3;
        chk(wr_seen - w0 == 3, "R4 write strobes", wr_seen - w0, 3);
        chk_bank("R5 wrap");

        // R6 fixed pointer
        w0 = wr_seen;
        bus_start();
        send_byte(8'h30, ack);
        send_byte(8'h05, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack); chk(ack, "R6 data ack", ack, 1);
        bus_stop();
        ebank[5] = 8'h33;
        chk(wr_seen - w0 == 3, "R6 write strobes", wr_seen - w0, 3);
        chk_bank("R6 same reg");

        // R3 wrong address
        w0 = wr_seen;
        viol = 0; quiet = 1;
        bus_start();
        send_byte(8'h32, ack); chk(!ack, "R3 no addr ack", ack, 0);
        send_byte(8'h01, ack); chk(!ack, "R3 no later ack", ack, 0);
        quiet = 0;
        bus_stop();
        chk(viol == 0, "R3 quiet", viol, 0);
        chk(wr_seen == w0, "R3 no write", wr_seen - w0, 0);

        // R7/R9 incrementing read after repeated START, R8 NACK
        bus_start();
        send_byte(8'h30, ack);
        send_byte(8'h8E, ack);
        bus_start();
        send_byte(8'h31, ack); chk(ack, "R9 restart addr ack", ack, 1);
        recv_byte(1'b1, rb); chk(rb == 8'hA1, "R7 read0", rb, 8'hA1);
        recv_byte(1'b1, rb); chk(rb == 8'hB2, "R7 read1", rb, 8'hB2);
        recv_byte(1'b0, rb); chk(rb == 8'hC3, "R7 read wrap", rb, 8'hC3);
        viol = 0; quiet = 1;
        recv_byte(1'b1, rb);
        quiet = 0;
        chk(viol == 0, "R8 released after nack", viol, 0);
        chk(rb == 8'hFF, "R8 idle line", rb, 8'hFF);
        bus_stop();

        // R7 non-incrementing read
        bus_start();
        send_byte(8'h30, ack);
        send_byte(8'h05, ack);
        bus_start();
        send_byte(8'h31, ack);
        recv_byte(1'b1, rb); chk(rb == 8'h33, "R7 fixed read0", rb, 8'h33);
        recv_byte(1'b0, rb); chk(rb == 8'h33, "R7 fixed read1", rb, 8'h33);
        bus_stop();

        // R9 pointer kept across STOP
        bus_start();
        send_byte(8'h31, ack); chk(ack, "R9 addr ack", ack, 1);
        recv_byte(1'b0, rb); chk(rb == 8'h33, "R9 pointer kept", rb, 8'h33);
        bus_stop();

        // R10 rising strap edge, R2 strap-dependent address
        sel = 1'b1; wt(10);
        chk(spi_mode == 1'b0, "R10 rise no switch", spi_mode, 0);
        bus_start();
        send_byte(8'h30, ack); chk(!ack, "R2 old addr rejected", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'h32, ack); chk(ack, "R2 strap addr ack", ack, 1);
        send_byte(8'h03, ack);
        send_byte(8'h5A, ack);
        bus_stop();
        ebank[3] = 8'h5A;
        chk_bank("R2 strap write");

        // R10 falling strap edge enters SPI mode for good
        sel = 1'b0; wt(10);
        chk(spi_mode == 1'b1, "R10 fall switch", spi_mode, 1);
        sel = 1'b1; wt(10);
        chk(spi_mode == 1'b1, "R10 sticky", spi_mode, 1);
        w0 = wr_seen;
        viol = 0; quiet = 1;
        bus_start();
        send_byte(8'h32, ack); chk(!ack, "R10 no ack", ack, 0);
        send_byte(8'h03, ack);
        send_byte(8'hEE, ack);
        bus_stop();
        quiet = 0;
        chk(viol == 0, "R10 quiet", viol, 0);
        chk(wr_seen == w0, "R10 no write", wr_seen - w0, 0);
        chk_bank("R10 bank intact");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule